// File: doc/BRIEF.md
# Fixed-Origin I2C Register Slave

This block is an I2C target for a device whose registers are reached without a pointer byte. The master addresses the device, and the byte stream that follows always lands on register zero first. Each further byte moves one register forward. A write burst fills the control-register bank. A read burst returns values from a parallel status bank that the surrounding logic supplies. Every new addressed transfer begins again at register zero, wherever the last one stopped.

The device address has seven bits. Its upper five bits are fixed by a parameter, and its two low bits follow two strap pins. The strap pins are watched all the time, so the address in force is the one present while the address byte arrives.

SCL and SDA are oversampled on the system clock. The block drives the bus only through an open-drain pull-down enable.

Top module: `i2c_ptr0_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low on the ninth clock) only when the first seven bits after a START equal {ADDR_HI, strap_i[1], strap_i[0]}, with ADDR_HI = 5'b00011 by default. On a mismatch it leaves SDA released and ignores every bit until the next START, so control registers keep their values.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A START seen in the middle of a transfer (repeated START) restarts address reception.
- R3: On a write (eighth address bit, the R/W bit, equal to 0), the first data byte is stored in control register 0 and each later byte in the next register. The slave acknowledges every data byte.
- R4: No byte is taken as a sub-address. Every addressed transfer, read or write, starts at register 0.
- R5: On a read (R/W bit equal to 1), after acknowledging the address the slave shifts out status register 0, MSB first. After each byte the master acknowledges, it sends the next status register.
- R6: A master not-acknowledge after a read byte ends the read and leaves SDA released. A STOP at any point ends the transfer, and a partly received byte is not stored.
- R7: The register index wraps from NREG-1 to 0 for both writes and reads (NREG = 16 by default).
- R8: The SDA pull-down enable changes only while the synchronized SCL is low.
- R9: The strap pins are sampled continuously. After they change, the new address is acknowledged and the old one is not.
- R10: After reset, all control registers are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| strap_i | input | 2 | Low two address bits from strap pins |
| stat_i | input | NREG*8 | Status bank, register k at bits [8k+7:8k] |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ctrl_o | output | NREG*8 | Control bank, register k at bits [8k+7:8k] |

## Verification
The bench builds the block with its defaults: sixteen registers, ADDR_HI of 5'b00011 and two synchronizer stages. Sixteen registers keep the wrap within reach of an 18-byte burst in both directions. The bench drives the bus four SCL quarters of eight clocks each, which leaves room for the synchronizer delay before each bus phase. Strap values 01 and 10 are both used, so a match on either low address bit is tested, and a mismatch in the fixed upper bits is tested too.

// File: rtl/i2c_ptr0_pkg.sv
package i2c_ptr0_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA, ST_WR_ACK, ST_RD_DATA, ST_RD_ACK
  } phase_e;

  // true when the received byte carries this device's 7-bit address
  function automatic logic addr_hit(input logic [7:0] rx, input logic [4:0] hi,
                                    input logic [1:0] strap);
    return rx[7:1] == {hi, strap};
  endfunction
endpackage

// File: rtl/i2c_ptr0_sampler.sv
module i2c_ptr0_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  timeunit 1ns; timeprecision 100ps;

  logic [1:0] raw, now, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[SYNC_STAGES-1:0], raw[g]};
    end
    assign now[g]  = pipe[SYNC_STAGES-1];
    assign prev[g] = pipe[SYNC_STAGES];
  end

  assign scl_s    = now[1];
  assign sda_s    = now[0];
  assign scl_rise = now[1] & ~prev[1];
  assign scl_fall = ~now[1] & prev[1];
  assign start_ev = now[1] & prev[1] & prev[0] & ~now[0];
  assign stop_ev  = now[1] & prev[1] & ~prev[0] & now[0];
endmodule

// File: rtl/i2c_ptr0_regbank.sv
module i2c_ptr0_regbank #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [PW-1:0]    rd_idx,
  input  logic [NREG*DW-1:0] stat_i,
  output logic [NREG*DW-1:0] ctrl_o,
  output logic [DW-1:0]    rd_data
);
  timeunit 1ns; timeprecision 100ps;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_o[g*DW +: DW] <= '0;
      else if (wr_en && wr_idx == PW'(g))  ctrl_o[g*DW +: DW] <= wr_data;
    end
  end

  assign rd_data = stat_i[int'(rd_idx)*DW +: DW];

  // R3
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_o[int'($past(wr_idx))*DW +: DW] == $past(wr_data));
endmodule

// File: rtl/i2c_ptr0_engine.sv
module i2c_ptr0_engine
  import i2c_ptr0_pkg::*;
#(
  parameter int         NREG    = 16,
  parameter logic [4:0] ADDR_HI = 5'b00011,
  localparam int        PW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [1:0]    strap_i,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [PW-1:0] reg_idx,
  output logic [7:0]    wr_data
);
  timeunit 1ns; timeprecision 100ps;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(NREG-1)) ? '0 : p + 1'b1;
  endfunction

  phase_e        st;
  logic [2:0]    cnt;
  logic [7:0]    sh;
  logic          rw, ack_half;
  logic [PW-1:0] ptr;
  logic [7:0]    rx_byte;
  logic          last_bit, hit_ev, miss_ev;

  assign rx_byte  = {sh[6:0], sda_s};
  assign last_bit = scl_rise && (cnt == 3'd7);
  assign hit_ev   = (st == ST_ADDR) && last_bit && addr_hit(rx_byte, ADDR_HI, strap_i);
  assign miss_ev  = (st == ST_ADDR) && last_bit && !hit_ev;
  assign wr_en    = (st == ST_WR_DATA) && last_bit;
  assign wr_data  = rx_byte;
  assign reg_idx  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0;
      ack_half <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_ev) begin
      st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: if (scl_rise) begin
          sh  <= rx_byte;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (hit_ev) begin
              st <= ST_ADDR_ACK; rw <= sda_s; ptr <= '0; ack_half <= 1'b0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: if (scl_fall) begin
          if (!ack_half) begin
            sda_oe <= 1'b1; ack_half <= 1'b1;
          end else begin
            ack_half <= 1'b0; cnt <= '0;
            if (st == ST_ADDR_ACK && rw) begin
              sh <= rd_data; sda_oe <= ~rd_data[7]; st <= ST_RD_DATA;
            end else begin
              sda_oe <= 1'b0; st <= ST_WR_DATA;
            end
          end
        end
        ST_WR_DATA: if (scl_rise) begin
          sh  <= rx_byte;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            ptr <= step(ptr); st <= ST_WR_ACK; ack_half <= 1'b0;
          end
        end
        ST_RD_DATA: if (scl_fall) begin
          if (cnt == 3'd7) begin
            sda_oe <= 1'b0; ptr <= step(ptr); st <= ST_RD_ACK;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 3'd1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise && sda_s) begin
            st <= ST_IDLE;
          end else if (scl_fall) begin
            sh <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0; st <= ST_RD_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  // R4
  ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (ptr == '0));
  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ptr == '0) == ($past(ptr) == PW'(NREG-1))));
  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE && !sda_oe));
  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_ADDR && cnt == 3'd0));
  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> (st == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2c_ptr0_slave.sv
module i2c_ptr0_slave #(
  parameter int         NREG        = 16,
  parameter logic [4:0] ADDR_HI     = 5'b00011,
  parameter int         SYNC_STAGES = 2,
  localparam int        DW          = 8,
  localparam int        PW          = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         strap_i,
  input  logic [NREG*DW-1:0] stat_i,
  output logic               sda_oe_o,
  output logic [NREG*DW-1:0] ctrl_o
);
  timeunit 1ns; timeprecision 100ps;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en;
  logic [PW-1:0] reg_idx;
  logic [DW-1:0] wr_data, rd_data;

  i2c_ptr0_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2c_ptr0_engine #(.NREG(NREG), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .strap_i(strap_i), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .reg_idx(reg_idx), .wr_data(wr_data));

  i2c_ptr0_regbank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(reg_idx), .wr_data(wr_data),
    .rd_idx(reg_idx), .stat_i(stat_i), .ctrl_o(ctrl_o), .rd_data(rd_data));
endmodule

// File: tb/i2c_ptr0_slave_tb.sv
module i2c_ptr0_slave_tb_top;
  timeunit 1ns; timeprecision 100ps;

  localparam int NREG = 16;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic [NREG*8-1:0] stat;
  logic sda_oe;
  logic [NREG*8-1:0] ctrl;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  i2c_ptr0_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .stat_i(stat), .sda_oe_o(sda_oe), .ctrl_o(ctrl));

  int total = 0, fails = 0, bad_edges = 0;
  logic [7:0] exp_ctrl [NREG];
  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] obs_q[$];

  function automatic logic [7:0] sval(input int i);
    return 8'(8'hC3 ^ (i * 37));
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask
  task automatic bus_restart();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask
  task automatic send_bit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask
  task automatic recv_bit(output logic b);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  // driver: push expected ack bit (0 = ack), then send the byte
  task automatic write_byte(input logic [7:0] d, input logic exp_nack, input string r);
    logic a;
    exp_q.push_back({7'd0, exp_nack}); req_q.push_back(r);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    obs_q.push_back({7'd0, a});
  endtask

  task automatic read_byte(input logic [7:0] e, input logic m_ack, input string r);
    logic [7:0] d;
    logic b;
    exp_q.push_back(e); req_q.push_back(r);
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    obs_q.push_back(d);
    send_bit(!m_ack);
  endtask

  function automatic logic [7:0] addr(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  task automatic check_bank(input string r);
    for (int i = 0; i < NREG; i++) chk(r, ctrl[i*8 +: 8], exp_ctrl[i]);
  endtask

  // monitor: pair observed items with expected ones
  initial begin : mon
    logic [7:0] o, e;
    string r;
    forever begin
      @(negedge clk);
      while (obs_q.size() != 0 && exp_q.size() != 0) begin
        o = obs_q.pop_front(); e = exp_q.pop_front(); r = req_q.pop_front();
        chk(r, o, e);
      end
    end
  end

  // R8: bench-side view of the pull-down changing while SCL is high
  initial begin : edge_mon
    logic prev_oe;
    prev_oe = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe !== prev_oe && m_scl === 1'b1) bad_edges++;
      prev_oe = sda_oe;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NREG; i++) begin
      stat[i*8 +: 8] = sval(i);
      exp_ctrl[i] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 sda released", {7'd0, sda_oe}, 8'h00);
    check_bank("R10 ctrl reset");

    // R1 R3: matching write of four bytes
    bus_start();
    write_byte(addr(7'b0001101, 1'b0), 1'b0, "R1 address ack");
    for (int k = 0; k < 4; k++) begin
      write_byte(8'h10 + 8'(k), 1'b0, "R3 data ack");
      exp_ctrl[k] = 8'h10 + 8'(k);
    end
    bus_stop();
    check_bank("R3 write burst");

    // R4: new write starts again at register 0
    bus_start();
    write_byte(addr(7'b0001101, 1'b0), 1'b0, "R4 address ack");
    write_byte(8'h5A, 1'b0, "R4 data ack");
    exp_ctrl[0] = 8'h5A;
    bus_stop();
    check_bank("R4 write origin");

    // R5 R6: read three bytes, NACK on the last
    bus_start();
    write_byte(addr(7'b0001101, 1'b1), 1'b0, "R5 address ack");
    read_byte(sval(0), 1'b1, "R5 read reg0");
    read_byte(sval(1), 1'b1, "R5 read reg1");
    read_byte(sval(2), 1'b0, "R5 read reg2");
    repeat (Q) @(negedge clk);
    chk("R6 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R4: read restarts at register 0
    bus_start();
    write_byte(addr(7'b0001101, 1'b1), 1'b0, "R4 read address ack");
    read_byte(sval(0), 1'b0, "R4 read origin");
    bus_stop();

    // R1: mismatches in low and high bits are ignored
    bus_start();
    write_byte(addr(7'b0001110, 1'b0), 1'b1, "R1 low-bit mismatch nack");
    write_byte(8'hEE, 1'b1, "R1 ignored data nack");
    bus_stop();
    bus_start();
    write_byte(addr(7'b1001101, 1'b0), 1'b1, "R1 high-bit mismatch nack");
    write_byte(8'hDD, 1'b1, "R1 ignored data nack");
    bus_stop();
    check_bank("R1 bank untouched");

    // R9: strap change moves the address
    strap = 2'b10;
    repeat (Q) @(negedge clk);
    bus_start();
    write_byte(addr(7'b0001101, 1'b0), 1'b1, "R9 old address nack");
    bus_stop();
    bus_start();
    write_byte(addr(7'b0001110, 1'b0), 1'b0, "R9 new address ack");
    write_byte(8'h77, 1'b0, "R9 data ack");
    exp_ctrl[0] = 8'h77;
    bus_stop();
    check_bank("R9 strap write");

    // R2 R4: write, repeated START, read from register 0
    bus_start();
    write_byte(addr(7'b0001110, 1'b0), 1'b0, "R2 address ack");
    write_byte(8'h11, 1'b0, "R2 data ack");
    write_byte(8'h22, 1'b0, "R2 data ack");
    exp_ctrl[0] = 8'h11; exp_ctrl[1] = 8'h22;
    bus_restart();
    write_byte(addr(7'b0001110, 1'b1), 1'b0, "R2 restart address ack");
    read_byte(sval(0), 1'b1, "R2 read after restart reg0");
    read_byte(sval(1), 1'b0, "R2 read after restart reg1");
    bus_stop();
    check_bank("R2 restart write");

    // R7: write burst of 18 wraps
    bus_start();
    write_byte(addr(7'b0001110, 1'b0), 1'b0, "R7 address ack");
    for (int k = 0; k < NREG + 2; k++) begin
      write_byte(8'hA0 ^ 8'(k * 5), 1'b0, "R7 data ack");
      exp_ctrl[k % NREG] = 8'hA0 ^ 8'(k * 5);
    end
    bus_stop();
    check_bank("R7 write wrap");

    // R7: read burst of 18 wraps
    bus_start();
    write_byte(addr(7'b0001110, 1'b1), 1'b0, "R7 read address ack");
    for (int k = 0; k < NREG + 2; k++)
      read_byte(sval(k % NREG), (k != NREG + 1), "R7 read wrap");
    bus_stop();

    // R6: STOP inside a data byte stores nothing partial
    bus_start();
    write_byte(addr(7'b0001110, 1'b0), 1'b0, "R6 address ack");
    write_byte(8'h3C, 1'b0, "R6 data ack");
    exp_ctrl[0] = 8'h3C;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    check_bank("R6 stop mid-byte");

    repeat (4 * Q) @(negedge clk);
    chk("R8 pull-down changes under high SCL", 8'(bad_edges), 8'h00);
    chk("R3 scoreboard drained", 8'(exp_q.size() + obs_q.size()), 8'h00);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule